// File: doc/BRIEF.md
# Instruction Address Sequencer with Three-Level Return Stack

This block produces the program-word address for a small 4-bit controller. A 10-bit program counter selects one of 1024 byte-wide program words. On every instruction cycle, marked by a one-clock strobe, the counter either moves to the following word or loads a new location. That location can be a full 10-bit target, a word inside the current page, or an address taken from the return stack. The address space is seen as 16 pages of 64 words: the upper four bits give the page and the lower six bits give the word within it.

Subroutine nesting uses three 10-bit save registers linked as a chain. A call pushes the return address in at the top, and each older entry moves one level down. A return takes the top entry, and each lower entry moves one level up. There is no pointer and no memory array. A skip from the surrounding decode logic is just a request for one extra increment, so the word that follows is passed over. Instruction decoding, the program store and skip evaluation sit outside this block.

Top module: `pcgen_top`

## Requirements
- R1: After reset the address is 0, the page output is 0 and all three save registers hold 0. A return issued straight after reset therefore yields address 0.
- R2: The address changes only on a clock edge where `cyc_en` is 1. On every other edge it keeps its value, whatever the operation, skip and target inputs are.
- R3: Operation code 3'b000 (sequential) loads the current address plus one, modulo 1024, so 1023 is followed by 0.
- R4: When `skip_i` is 1 with the sequential operation, the address advances by two, modulo 1024 (1022 goes to 0 and 1023 goes to 1). With every non-sequential operation `skip_i` has no effect.
- R5: Operation code 3'b001 (far jump) loads all ten bits of `target_i`.
- R6: Operation code 3'b010 (page jump) keeps address bits [9:6] and loads bits [5:0] from `target_i[5:0]`. `target_i[9:6]` is ignored.
- R7: Operation code 3'b011 (call) loads `target_i` and pushes the current address plus one, modulo 1024, onto the top save register. The older entries move down one level, and on a fourth nested call the oldest entry is lost.
- R8: Operation code 3'b100 (return) loads the top save register. The lower entries move up one level and the bottom entry keeps its value, so returns beyond the depth repeat the deepest saved address.
- R9: `page_o` always equals address bits [9:6], and `pc_o` is the full current address.
- R10: The unused operation codes 3'b101, 3'b110 and 3'b111 behave exactly like the sequential operation, skip included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle strobe; the address updates on edges where it is 1 |
| op_i | input | 3 | Operation: 000 sequential, 001 far jump, 010 page jump, 011 call, 100 return, others as sequential |
| skip_i | input | 1 | Extra-increment request, used with the sequential operation only |
| target_i | input | 10 | Transfer target address |
| pc_o | output | 10 | Current program address |
| page_o | output | 4 | Current page (address bits [9:6]) |

## Verification
The bench drives the increment and the double increment across the top of the address space. A counter of the wrong width or with a carry into the wrong place would fail to wrap from 1023 to 0, or from 1023 to 1. A page jump is given a target whose upper bits differ from the current page, which exposes a design that loads all ten bits. Four nested calls followed by four returns show whether the oldest entry is really dropped and whether the bottom entry is kept: a stack that cleared its bottom entry would return to 0, and one that did not shift would return the wrong order. A call from address 1023, strobe-free cycles carrying live commands, and a skip presented with a jump catch a return address without wrap, updates that ignore the strobe, and skips that leak into transfers.

// File: rtl/pcgen_pkg.sv
package pcgen_pkg;
    localparam int PC_W   = 10;
    localparam int PAGE_W = 4;
    localparam int WORD_W = PC_W - PAGE_W;
    localparam int DEPTH  = 3;

    typedef enum logic [2:0] {
        OP_SEQ   = 3'd0,
        OP_JFAR  = 3'd1,
        OP_JPAGE = 3'd2,
        OP_CALL  = 3'd3,
        OP_RET   = 3'd4
    } pc_op_e;

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pc_state_t;
endpackage

// File: rtl/pcgen_next.sv
module pcgen_next
    import pcgen_pkg::*;
#(
    parameter int AW = PC_W,
    parameter int WW = WORD_W
) (
    input  logic [AW-1:0] pc_i,
    input  logic [2:0]    op_i,
    input  logic          skip_i,
    input  logic [AW-1:0] target_i,
    input  logic [AW-1:0] top_i,
    output logic [AW-1:0] next_pc_o,
    output logic [AW-1:0] ret_addr_o,
    output logic          push_o,
    output logic          pop_o
);
    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] TWO = AW'(2);

    logic [AW-1:0] inc1, inc2;

    always_comb begin
        inc1       = pc_i + ONE;
        inc2       = pc_i + TWO;
        ret_addr_o = inc1;
        push_o     = 1'b0;
        pop_o      = 1'b0;
        next_pc_o  = skip_i ? inc2 : inc1;
        case (op_i)
            OP_JFAR:  next_pc_o = target_i;
            OP_JPAGE: next_pc_o = {pc_i[AW-1:WW], target_i[WW-1:0]};
            OP_CALL: begin
                next_pc_o = target_i;
                push_o    = 1'b1;
            end
            OP_RET: begin
                next_pc_o = top_i;
                pop_o     = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pcgen_stack.sv
module pcgen_stack
    import pcgen_pkg::*;
#(
    parameter int AW = PC_W,
    parameter int SD = DEPTH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [AW-1:0] data_i,
    output logic [AW-1:0] top_o
);
    typedef struct packed {
        logic [SD-1:0][AW-1:0] lvl;
    } stk_t;

    stk_t stk_d, stk_q;

    always_comb begin
        stk_d = stk_q;
        if (push_i) begin
            stk_d.lvl[0] = data_i;
            for (int i = 1; i < SD; i++) begin
                stk_d.lvl[i] = stk_q.lvl[i-1];
            end
        end else if (pop_i) begin
            for (int i = 0; i < SD - 1; i++) begin
                stk_d.lvl[i] = stk_q.lvl[i+1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    assign top_o = stk_q.lvl[0];

    // R7: a pushed return address shows up at the top
    p_push_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> stk_q.lvl[0] == $past(data_i));

    // R7: a push moves the previous top one level down
    p_push_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> stk_q.lvl[1] == $past(stk_q.lvl[0]));

    // R8: a pop leaves the bottom entry untouched
    p_bottom_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> stk_q.lvl[SD-1] == $past(stk_q.lvl[SD-1]));
endmodule

// File: rtl/pcgen_top.sv
module pcgen_top
    import pcgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic [2:0]        op_i,
    input  logic              skip_i,
    input  logic [PC_W-1:0]   target_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [PAGE_W-1:0] page_o
);
    pc_state_t       st_d, st_q;
    logic [PC_W-1:0] nxt_pc, ret_addr, top_entry;
    logic            push_req, pop_req;

    pcgen_next #(.AW(PC_W), .WW(WORD_W)) u_next (
        .pc_i      (st_q.pc),
        .op_i      (op_i),
        .skip_i    (skip_i),
        .target_i  (target_i),
        .top_i     (top_entry),
        .next_pc_o (nxt_pc),
        .ret_addr_o(ret_addr),
        .push_o    (push_req),
        .pop_o     (pop_req)
    );

    pcgen_stack #(.AW(PC_W), .SD(DEPTH)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push_i(push_req & cyc_en),
        .pop_i (pop_req & cyc_en),
        .data_i(ret_addr),
        .top_o (top_entry)
    );

    always_comb begin
        st_d = st_q;
        if (cyc_en) st_d.pc = nxt_pc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_o   = st_q.pc;
    assign page_o = st_q.pc[PC_W-1:WORD_W];

    // R2: no strobe, no movement
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en |=> $stable(pc_o));

    // R3: plain sequential step
    p_seq_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && op_i == OP_SEQ && !skip_i) |=> pc_o == $past(pc_o) + PC_W'(1));

    // R6: page jump keeps the page
    p_page_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && op_i == OP_JPAGE) |=> page_o == $past(page_o));

    // R8: return loads the top save register
    p_ret_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && op_i == OP_RET) |=> pc_o == $past(top_entry));

    // R5: far jump loads the target
    p_jfar_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && op_i == OP_JFAR) |=> pc_o == $past(target_i));
endmodule

// File: tb/pcgen_top_tb.sv
module pcgen_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0;
    logic [2:0] op_i = 3'd0;
    logic       skip_i = 1'b0;
    logic [9:0] target_i = '0;
    logic [9:0] pc_o;
    logic [3:0] page_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct {
        logic [9:0] pc;
        string      tag;
    } exp_t;
    exp_t sb[$];

    logic [9:0] m_pc = '0;
    logic [9:0] m_stk [3] = '{10'd0, 10'd0, 10'd0};

    always #2.5 clk = ~clk;

    pcgen_top u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .op_i(op_i),
        .skip_i(skip_i), .target_i(target_i), .pc_o(pc_o), .page_o(page_o)
    );

    task automatic compare(input logic [9:0] exp_pc, input string tag);
        n_chk++;
        if (pc_o !== exp_pc || page_o !== exp_pc[9:6]) begin
            n_bad++;
            $display("FAIL %s: pc=%h page=%h expected pc=%h page=%h",
                     tag, pc_o, page_o, exp_pc, exp_pc[9:6]);
        end
    endtask

    // monitor: pops expected items one half-cycle after the edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            compare(e.pc, e.tag);
        end
    end

    // driver: model computes expectation, item is queued after the edge
    task automatic step(input logic en, input logic [2:0] op, input logic sk,
                        input logic [9:0] tgt, input string tag);
        logic [9:0] nx;
        @(negedge clk);
        cyc_en = en; op_i = op; skip_i = sk; target_i = tgt;
        nx = m_pc;
        if (en) begin
            case (op)
                3'd1: nx = tgt;
                3'd2: nx = {m_pc[9:6], tgt[5:0]};
                3'd3: begin
                    nx = tgt;
                    m_stk[2] = m_stk[1]; m_stk[1] = m_stk[0]; m_stk[0] = m_pc + 10'd1;
                end
                3'd4: begin
                    nx = m_stk[0];
                    m_stk[0] = m_stk[1]; m_stk[1] = m_stk[2];
                end
                default: nx = m_pc + (sk ? 10'd2 : 10'd1);
            endcase
        end
        m_pc = nx;
        @(posedge clk);
        #1;
        sb.push_back('{nx, tag});
    endtask

    initial begin
        #200000;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        n_chk++; n_bad++;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(10'd0, "R1 reset address");
        rst_n = 1'b1;
        step(1, 3'd4, 0, 10'h155, "R1 return after reset gives 0");
        step(1, 3'd0, 0, 10'h0,   "R3 seq 0->1");
        step(1, 3'd0, 0, 10'h0,   "R3 seq 1->2");
        step(0, 3'd3, 1, 10'h2AA, "R2 no strobe with call");
        step(0, 3'd1, 0, 10'h111, "R2 no strobe with jump");
        step(1, 3'd1, 0, 10'h3FE, "R5 far jump 3FE");
        step(1, 3'd0, 0, 10'h0,   "R3 seq 3FE->3FF");
        step(1, 3'd0, 0, 10'h0,   "R3 wrap 3FF->0");
        step(1, 3'd1, 0, 10'h3FE, "R5 far jump 3FE");
        step(1, 3'd0, 1, 10'h0,   "R4 skip 3FE->0");
        step(1, 3'd1, 0, 10'h3FF, "R5 far jump 3FF");
        step(1, 3'd0, 1, 10'h0,   "R4 skip 3FF->1");
        step(1, 3'd1, 0, 10'h150, "R9 far jump page 5");
        step(1, 3'd2, 0, 10'h3AB, "R6 page jump keeps page 5");
        step(1, 3'd1, 1, 10'h200, "R4 skip ignored on jump");
        step(1, 3'd3, 0, 10'h100, "R7 call 1");
        step(1, 3'd3, 0, 10'h080, "R7 call 2");
        step(1, 3'd3, 0, 10'h040, "R7 call 3");
        step(1, 3'd3, 1, 10'h020, "R7 call 4 drops oldest, skip ignored");
        step(1, 3'd4, 0, 10'h0,   "R8 return to 041");
        step(1, 3'd4, 0, 10'h0,   "R8 return to 081");
        step(1, 3'd4, 0, 10'h0,   "R8 return to 101");
        step(1, 3'd4, 0, 10'h0,   "R8 return repeats bottom 101");
        step(1, 3'd1, 0, 10'h3FF, "R5 far jump 3FF");
        step(1, 3'd3, 0, 10'h010, "R7 call from 3FF");
        step(1, 3'd4, 0, 10'h0,   "R7 return address wrapped to 0");
        step(1, 3'd5, 0, 10'h2FF, "R10 code 5 as seq");
        step(1, 3'd6, 0, 10'h2FF, "R10 code 6 as seq");
        step(1, 3'd7, 1, 10'h2FF, "R10 code 7 with skip");
        step(0, 3'd0, 0, 10'h0,   "R2 idle tail");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule